// File: doc/BRIEF.md
# Event Ring Completion Writer

This block produces completion events for a ring-based DMA engine. Every time the transfer side retires a descriptor, it offers the block a completion with a 4-bit completion code and a 4-bit error detail. Code 1 means success and code 4 means error; other values pass through unchanged. The block turns each completion into a 16-byte record and writes it into a circular event ring in memory, one 32-bit word per cycle. Once the whole record is out, it moves a byte-offset write pointer forward. Software reads records up to that pointer and hands space back by writing its consumed byte offset to a doorbell input.

The control is a three-state machine:
- **ST_IDLE** waits for a completion. The transition *accept* (valid and ready) leads to ST_EMIT.
- **ST_EMIT** issues the four record words. The transition *last_word* leads to ST_COMMIT.
- **ST_COMMIT** moves the write pointer forward and raises the end-of-block pulse if the descriptor asked for one. The transition *done* returns to ST_IDLE.

When the ring is full, ST_IDLE holds `cmp_ready` low, which stalls the transfer engine.

Top module: `evt_ring_writer`

## Requirements
- R1: An accepted completion produces exactly four 32-bit memory writes, one per consecutive cycle, at byte addresses wr_ptr, wr_ptr+4, wr_ptr+8 and wr_ptr+12. The first write appears in the cycle after the accepting clock edge.
- R2: Word 0 of a record holds the completion code in bits 31:28 and the error detail in bits 27:24; all its other bits are zero. Words 1, 2 and 3 are zero.
- R3: The write pointer moves forward by 16 once per record. When the new value would reach the ring length, it wraps to 0 instead.
- R4: The write pointer is always a multiple of 16 and always below the ring length.
- R5: Records land in the ring in the same order in which their completions were accepted. Each record's contents are those of its own completion.
- R6: The ring counts as full when the forward-moved, wrapped write pointer would equal the software read offset. While the ring is full, `cmp_ready` is low, no completion is accepted, no memory write occurs and the pointer holds.
- R7: A doorbell write loads the software read offset at the next clock edge. Reset sets the read offset to 0. A doorbell write that removes the full condition raises `cmp_ready` again in the cycle that follows the doorbell edge.
- R8: `eob_pulse` is high for exactly one cycle per record, in the cycle after the fourth word, and only when `cmp_eob_req` was set at acceptance. This input carries bit 16 of the descriptor configuration word.
- R9: After reset, wr_ptr is 0, no write or pulse is active and `cmp_ready` is high.
- R10: The write pointer keeps its old value during all four word writes and during the cycle after them. It takes its new value at the edge that ends ST_COMMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_len | input | ADDR_W | Ring length in bytes; a multiple of 16, at least 32 |
| cmp_valid | input | 1 | Completion offered |
| cmp_ready | output | 1 | Completion can be taken this cycle |
| cmp_code | input | 4 | Completion code (1 success, 4 error) |
| cmp_info | input | 4 | Error detail |
| cmp_eob_req | input | 1 | Descriptor asked for an end-of-block event (its config bit 16) |
| dbl_wr | input | 1 | Doorbell write strobe |
| dbl_off | input | ADDR_W | Consumed byte offset written by software |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Byte address of the word being written |
| mem_wr_data | output | 32 | Word being written |
| wr_ptr | output | ADDR_W | Hardware write pointer, as a byte offset |
| eob_pulse | output | 1 | End-of-block event pulse |

## Verification
The main path runs through a table of completions with varied codes, detail values and end-of-block requests, in a ring of six slots. This lets misplaced nibbles, stray nonzero words and requests that go unflagged show up separately. Because the table is longer than the ring, the same sequence also exercises the pointer wrap and ordering across the ring boundary. A separate pass leaves the doorbell unwritten until the ring fills. It confirms that a completion held valid causes no write and no pointer movement, then that a single doorbell write releases it.

// File: rtl/evr_pkg.sv
package evr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_COMMIT = 2'd2
    } evr_state_e;

    localparam int REC_BYTES     = 16;
    localparam int WORD_BYTES    = 4;
    localparam int REC_WORDS     = REC_BYTES / WORD_BYTES;
    localparam int BEAT_W        = $clog2(REC_WORDS);
    localparam int DATA_W        = 32;
    localparam int CODE_LSB      = 28;
    localparam int INFO_LSB      = 24;
    localparam int NIB_W         = 4;

endpackage

// File: rtl/evr_ring_ptr.sv
module evr_ring_ptr
    import evr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_len,
    input  logic              advance,
    input  logic              dbl_wr,
    input  logic [ADDR_W-1:0] dbl_off,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              ring_full
);

    localparam logic [ADDR_W:0] STEP_EXT = (ADDR_W+1)'(REC_BYTES);

    logic [ADDR_W-1:0] wr_ptr_q;
    logic [ADDR_W-1:0] rd_off_q;
    logic [ADDR_W:0]   step_sum;
    logic [ADDR_W-1:0] next_ptr;

    always_comb begin
        step_sum = {1'b0, wr_ptr_q} + STEP_EXT;
        if (step_sum >= {1'b0, ring_len}) begin
            next_ptr = '0;
        end else begin
            next_ptr = step_sum[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_off_q <= '0;
        end else begin
            if (advance) begin
                wr_ptr_q <= next_ptr;
            end
            if (dbl_wr) begin
                rd_off_q <= dbl_off;
            end
        end
    end

    assign wr_ptr    = wr_ptr_q;
    assign ring_full = (next_ptr == rd_off_q);

    // R3: every pointer change is one record step or a wrap to zero
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr_q != $past(wr_ptr_q)) |->
            ((wr_ptr_q == '0) || (wr_ptr_q == $past(wr_ptr_q) + ADDR_W'(REC_BYTES))));

    // R4: pointer stays aligned and inside the ring
    p_ptr_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr_q[3:0] == 4'd0) && (wr_ptr_q < ring_len));

endmodule

// File: rtl/evr_word_pack.sv
module evr_word_pack
    import evr_pkg::*;
(
    input  logic [BEAT_W-1:0] beat,
    input  logic [NIB_W-1:0]  code,
    input  logic [NIB_W-1:0]  info,
    output logic [DATA_W-1:0] word
);

    always_comb begin
        word = '0;
        if (beat == '0) begin
            word[CODE_LSB +: NIB_W] = code;
            word[INFO_LSB +: NIB_W] = info;
        end
    end

endmodule

// File: rtl/evt_ring_writer.sv
module evt_ring_writer
    import evr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_len,
    input  logic              cmp_valid,
    output logic              cmp_ready,
    input  logic [3:0]        cmp_code,
    input  logic [3:0]        cmp_info,
    input  logic              cmp_eob_req,
    input  logic              dbl_wr,
    input  logic [ADDR_W-1:0] dbl_off,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              eob_pulse
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(REC_WORDS - 1);

    evr_state_e        state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic [NIB_W-1:0]  code_q, info_q;
    logic              eob_req_q;
    logic              accept;
    logic              advance;
    logic              ring_full;
    logic [DATA_W-1:0] packed_word;

    evr_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ring_len  (ring_len),
        .advance   (advance),
        .dbl_wr    (dbl_wr),
        .dbl_off   (dbl_off),
        .wr_ptr    (wr_ptr),
        .ring_full (ring_full)
    );

    evr_word_pack u_pack (
        .beat (beat_q),
        .code (code_q),
        .info (info_q),
        .word (packed_word)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_EMIT;
                    beat_d  = '0;
                end
            end
            ST_EMIT: begin
                if (beat_q == LAST_BEAT) begin
                    state_d = ST_COMMIT;
                end else begin
                    beat_d = beat_q + 1'b1;
                end
            end
            ST_COMMIT: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register and captured completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            beat_q    <= '0;
            code_q    <= '0;
            info_q    <= '0;
            eob_req_q <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            if (accept) begin
                code_q    <= cmp_code;
                info_q    <= cmp_info;
                eob_req_q <= cmp_eob_req;
            end
        end
    end

    // outputs
    always_comb begin
        cmp_ready   = 1'b0;
        mem_wr_en   = 1'b0;
        mem_wr_addr = wr_ptr;
        mem_wr_data = '0;
        eob_pulse   = 1'b0;
        advance     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmp_ready = !ring_full;
            end
            ST_EMIT: begin
                mem_wr_en   = 1'b1;
                mem_wr_addr = wr_ptr + ADDR_W'({beat_q, 2'b00});
                mem_wr_data = packed_word;
            end
            ST_COMMIT: begin
                advance   = 1'b1;
                eob_pulse = eob_req_q;
            end
            default: begin
                cmp_ready = 1'b0;
            end
        endcase
    end

    assign accept = cmp_valid && cmp_ready;

    // R1: consecutive words of a record step by one word address
    p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_wr_en)) |->
            (mem_wr_addr == $past(mem_wr_addr) + ADDR_W'(WORD_BYTES)));

    // R10: pointer does not move right after a word write
    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (wr_ptr == $past(wr_ptr)));

    // R6: a full ring never offers ready
    p_stall_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ring_full |-> !cmp_ready);

    // R8: the end-of-block pulse follows a write burst and is a single cycle
    p_eob_after_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eob_pulse |-> ($past(mem_wr_en) && !mem_wr_en));

    p_eob_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eob_pulse |=> !eob_pulse);

endmodule

// File: tb/evt_ring_writer_bench.sv
module evt_ring_writer_bench;

    localparam int ADDR_W   = 16;
    localparam int RING     = 96;
    localparam int NVEC     = 8;
    localparam int WD_LIMIT = 20000;

    // each entry: {code[3:0], info[3:0], eob_req}
    localparam logic [8:0] VEC [NVEC] = '{
        {4'd1, 4'h0, 1'b1},
        {4'd4, 4'hA, 1'b0},
        {4'd1, 4'h5, 1'b0},
        {4'd4, 4'hF, 1'b1},
        {4'hF, 4'h3, 1'b1},
        {4'd1, 4'hC, 1'b0},
        {4'd4, 4'h1, 1'b1},
        {4'h8, 4'h7, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] ring_len = ADDR_W'(RING);
    logic              cmp_valid = 1'b0;
    logic              cmp_ready;
    logic [3:0]        cmp_code = '0;
    logic [3:0]        cmp_info = '0;
    logic              cmp_eob_req = 1'b0;
    logic              dbl_wr = 1'b0;
    logic [ADDR_W-1:0] dbl_off = '0;
    logic              mem_wr_en;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [31:0]       mem_wr_data;
    logic [ADDR_W-1:0] wr_ptr;
    logic              eob_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ptr = 0;
    int rd_sw = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    evt_ring_writer #(.ADDR_W(ADDR_W)) u_evt_ring_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ring_len    (ring_len),
        .cmp_valid   (cmp_valid),
        .cmp_ready   (cmp_ready),
        .cmp_code    (cmp_code),
        .cmp_info    (cmp_info),
        .cmp_eob_req (cmp_eob_req),
        .dbl_wr      (dbl_wr),
        .dbl_off     (dbl_off),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .wr_ptr      (wr_ptr),
        .eob_pulse   (eob_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic ring_bell(input int off);
        dbl_wr  = 1'b1;
        dbl_off = ADDR_W'(off);
        rd_sw   = off;
        @(negedge clk);
        dbl_wr  = 1'b0;
    endtask

    task automatic push(input logic [3:0] c, input logic [3:0] i, input logic req);
        logic [31:0] w0;
        w0 = {c, i, 24'h0};
        cmp_valid   = 1'b1;
        cmp_code    = c;
        cmp_info    = i;
        cmp_eob_req = req;
        while (!cmp_ready) @(negedge clk);
        @(negedge clk);
        cmp_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(mem_wr_en == 1'b1, "R1", "write strobe", 32'(mem_wr_en), 32'd1);
            chk(mem_wr_addr == ADDR_W'(exp_ptr + 4*k), "R1", "word address",
                32'(mem_wr_addr), 32'(exp_ptr + 4*k));
            chk(mem_wr_data == ((k == 0) ? w0 : 32'h0), "R2 R5", "word data",
                mem_wr_data, (k == 0) ? w0 : 32'h0);
            chk(eob_pulse == 1'b0, "R8", "pulse during words", 32'(eob_pulse), 32'd0);
            chk(wr_ptr == ADDR_W'(exp_ptr), "R10", "pointer during words",
                32'(wr_ptr), 32'(exp_ptr));
            @(negedge clk);
        end
        chk(mem_wr_en == 1'b0, "R1", "no fifth write", 32'(mem_wr_en), 32'd0);
        chk(eob_pulse == req, "R8", "end-of-block pulse", 32'(eob_pulse), 32'(req));
        chk(wr_ptr == ADDR_W'(exp_ptr), "R10", "pointer before commit",
            32'(wr_ptr), 32'(exp_ptr));
        @(negedge clk);
        exp_ptr = (exp_ptr + 16 >= RING) ? 0 : exp_ptr + 16;
        chk(wr_ptr == ADDR_W'(exp_ptr), "R3", "pointer after commit",
            32'(wr_ptr), 32'(exp_ptr));
        chk(eob_pulse == 1'b0, "R8", "pulse one cycle", 32'(eob_pulse), 32'd0);
    endtask

    initial begin
        #(WD_LIMIT * 8);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(wr_ptr == '0, "R9", "pointer after reset", 32'(wr_ptr), 32'd0);
        chk(mem_wr_en == 1'b0, "R9", "no write after reset", 32'(mem_wr_en), 32'd0);
        chk(eob_pulse == 1'b0, "R9", "no pulse after reset", 32'(eob_pulse), 32'd0);
        chk(cmp_ready == 1'b1, "R9", "ready after reset", 32'(cmp_ready), 32'd1);

        // table pass: consume each record, cross the wrap (R3 R5)
        for (int v = 0; v < NVEC; v++) begin
            push(VEC[v][8:5], VEC[v][4:1], VEC[v][0]);
            ring_bell(exp_ptr);
        end
        chk(wr_ptr == ADDR_W'(32), "R3", "pointer after wrap", 32'(wr_ptr), 32'd32);

        // R6: fill the ring with no doorbell; five slots fit in six
        for (int n = 0; n < 5; n++) begin
            push(4'd1, 4'(n), 1'b0);
        end
        chk(cmp_ready == 1'b0, "R6", "ready low when full", 32'(cmp_ready), 32'd0);
        cmp_valid   = 1'b1;
        cmp_code    = 4'd4;
        cmp_info    = 4'h9;
        cmp_eob_req = 1'b1;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            chk(mem_wr_en == 1'b0, "R6", "no write while full", 32'(mem_wr_en), 32'd0);
            chk(wr_ptr == ADDR_W'(exp_ptr), "R6", "pointer held while full",
                32'(wr_ptr), 32'(exp_ptr));
            chk(cmp_ready == 1'b0, "R6", "ready held low", 32'(cmp_ready), 32'd0);
        end
        // R7: one doorbell step frees one slot
        ring_bell((rd_sw + 16) % RING);
        chk(cmp_ready == 1'b1, "R7", "ready after doorbell", 32'(cmp_ready), 32'd1);
        push(4'd4, 4'h9, 1'b1);
        chk(cmp_ready == 1'b0, "R6", "full again", 32'(cmp_ready), 32'd0);
        chk(wr_ptr[3:0] == 4'd0 && wr_ptr < ring_len, "R4", "pointer aligned and bounded",
            32'(wr_ptr), 32'(exp_ptr));

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule